// File: doc/BRIEF.md
# Receiver Frame Parser with Resynchronisation

The parser reads 32-bit words from the read side of one receiver input FIFO. The FIFO is first-word-fall-through: its head word is visible whenever it is not empty. The parser splits the word stream into frames. A frame opens with a header keyword. The next word carries the event number and the bunch-crossing number. Data words follow, and a footer keyword closes the frame. Accepted words are passed on through a registered valid/ready output. Start-of-frame and end-of-frame markers travel with the words, and the extracted event and bunch-crossing numbers are held on their own outputs. An event builder downstream can then compare them with its trigger queue.

Three malformations are reported separately through a one-cycle error strobe with a two-bit type code, and each type has a saturating counter:
- an oversize frame;
- a frame cut short by a new header before its footer;
- words that arrive where a header was expected.

After an oversize frame or a missing header, the parser consumes words without forwarding them until it sees the next header. An abort input drops the parser into the same skipping state, so that the builder can resynchronise it after a timeout.

Top module: `rxf_parser`

## Requirements
- R1: A word whose bits [31:24] equal `hdr_key` opens a frame and is forwarded with `out_sof`=1. A word whose bits [31:24] equal `ftr_key`, seen after the ID word, is forwarded with `out_eof`=1 and closes the frame. All frame words reach `out_data` in order, and `out_valid` rises on the clock edge that pops the word from the FIFO.
- R2: The word after a header is the ID word. Its bits [31:12] appear on `out_evid` and its bits [11:0] on `out_bcid`, from the edge at which that word is presented. Both hold until the next ID word.
- R3: A frame may hold at most `max_len` words, counting the header and the footer. The word that would be word `max_len`+1 raises error code 1 (oversize). That word and every following word up to the next header are consumed and not forwarded.
- R4: A header that arrives while a frame is open (after its header and before its footer) raises error code 2 (incomplete). That header is forwarded with `out_sof`=1 as the start of a new frame.
- R5: A non-header word that arrives while a header is expected raises error code 3 (corrupted) once. Words are then consumed without forwarding and without further errors until a header arrives.
- R6: `err_stb` is high for exactly one cycle per error, and `err_code` holds the type during that cycle. `err_code` is 0 whenever `err_stb` is low.
- R7: `cnt_jumbo`, `cnt_incomplete` and `cnt_corrupt` count errors of codes 1, 2 and 3. Each saturates at its all-ones value. All are 0 after reset.
- R8: While `abort` is high, no word is read. After an abort, words are consumed without forwarding and without errors until the next header.
- R9: While `out_valid`=1 and `out_ready`=0, no word is read and `out_data`, `out_sof` and `out_eof` stay stable.
- R10: `fifo_rd` is never high while `fifo_empty` is high.
- R11: During and right after reset, `out_valid`, `err_stb`, `err_code` and all counters are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_data | input | 32 | Head word of the input FIFO |
| fifo_empty | input | 1 | Input FIFO holds no word |
| fifo_rd | output | 1 | Pops the head word this cycle |
| hdr_key | input | 8 | Header keyword matched against bits [31:24] |
| ftr_key | input | 8 | Footer keyword matched against bits [31:24] |
| max_len | input | LEN_W | Largest allowed frame length in words |
| abort | input | 1 | Forces the skip-until-header state |
| out_data | output | 32 | Forwarded word |
| out_sof | output | 1 | Forwarded word is a header |
| out_eof | output | 1 | Forwarded word is a footer |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts the output word |
| out_evid | output | EVID_W | Event number of the latest ID word |
| out_bcid | output | 32-EVID_W | Bunch-crossing number of the latest ID word |
| err_stb | output | 1 | One-cycle error pulse |
| err_code | output | 2 | 1 oversize, 2 incomplete, 3 corrupted |
| cnt_jumbo | output | CNT_W | Saturating count of oversize errors |
| cnt_incomplete | output | CNT_W | Saturating count of incomplete errors |
| cnt_corrupt | output | CNT_W | Saturating count of corrupted errors |

## Verification
The hardest case to reach from the ports is a frame that runs exactly to the length limit, placed next to one that runs a single word past it. The stimulus places the two side by side with a small `max_len`, so that the boundary word and the words skipped after it are told apart in one run. The abort case takes timing: the bench raises `abort` while a frame is open and words are waiting in the FIFO, then shows that the footer of the cut frame is swallowed silently. Counter saturation is reached by giving the bench instance a 4-bit counter width and repeating a corrupted prefix more than 15 times.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    localparam int WORD_W = 32;
    localparam int KEY_W  = 8;

    typedef enum logic [1:0] {
        PS_EXPECT = 2'd0,
        PS_IDWORD = 2'd1,
        PS_BODY   = 2'd2,
        PS_SKIP   = 2'd3
    } pstate_t;

    typedef enum logic [1:0] {
        EC_NONE       = 2'd0,
        EC_JUMBO      = 2'd1,
        EC_INCOMPLETE = 2'd2,
        EC_CORRUPT    = 2'd3
    } errc_t;

    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic              sof;
        logic              eof;
    } beat_t;

    function automatic logic key_hit(input logic [WORD_W-1:0] w,
                                     input logic [KEY_W-1:0]  k);
        return w[WORD_W-1 -: KEY_W] == k;
    endfunction

endpackage

// File: rtl/rxf_classify.sv
module rxf_classify
    import rxf_pkg::*;
#(
    parameter int LEN_W = 12
) (
    input  logic [WORD_W-1:0] word,
    input  logic [KEY_W-1:0]  hdr_key,
    input  logic [KEY_W-1:0]  ftr_key,
    input  logic [LEN_W-1:0]  len_cur,
    input  logic [LEN_W-1:0]  max_len,
    output logic              is_hdr,
    output logic              is_ftr,
    output logic              over_len
);
    logic [LEN_W:0] len_next;

    always_comb begin
        is_hdr   = key_hit(word, hdr_key);
        is_ftr   = key_hit(word, ftr_key);
        len_next = {1'b0, len_cur} + 1'b1;
        over_len = len_next > {1'b0, max_len};
    end
endmodule

// File: rtl/rxf_errcnt.sv
module rxf_errcnt
    import rxf_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int NTYPE = 3
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        stb,
    input  errc_t                       code,
    output logic [NTYPE-1:0][CNT_W-1:0] cnt
);
    for (genvar g = 0; g < NTYPE; g++) begin : g_cnt
        always_ff @(posedge clk) begin
            if (rst) begin
                cnt[g] <= '0;
            end else if (stb && (int'(code) == g + 1) && (cnt[g] != '1)) begin
                cnt[g] <= cnt[g] + 1'b1;
            end
        end
    end
endmodule

// File: rtl/rxf_parser.sv
module rxf_parser
    import rxf_pkg::*;
#(
    parameter int LEN_W  = 12,
    parameter int EVID_W = 20,
    parameter int CNT_W  = 16,
    localparam int BCID_W = WORD_W - EVID_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [31:0]       fifo_data,
    input  logic              fifo_empty,
    output logic              fifo_rd,
    input  logic [7:0]        hdr_key,
    input  logic [7:0]        ftr_key,
    input  logic [LEN_W-1:0]  max_len,
    input  logic              abort,
    output logic [31:0]       out_data,
    output logic              out_sof,
    output logic              out_eof,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [EVID_W-1:0] out_evid,
    output logic [BCID_W-1:0] out_bcid,
    output logic              err_stb,
    output logic [1:0]        err_code,
    output logic [CNT_W-1:0]  cnt_jumbo,
    output logic [CNT_W-1:0]  cnt_incomplete,
    output logic [CNT_W-1:0]  cnt_corrupt
);
    localparam int NTYPE = 3;

    pstate_t state_q, state_d;
    logic [LEN_W-1:0] len_q, len_d;
    beat_t beat_q, beat_d;
    logic valid_q, fwd, cap_id, rd;
    errc_t err_d, err_q;
    logic err_stb_q;
    logic [EVID_W-1:0] evid_q;
    logic [BCID_W-1:0] bcid_q;
    logic is_hdr, is_ftr, over_len;
    logic [NTYPE-1:0][CNT_W-1:0] cnt;

    rxf_classify #(.LEN_W(LEN_W)) i_cls (
        .word     (fifo_data),
        .hdr_key  (hdr_key),
        .ftr_key  (ftr_key),
        .len_cur  (len_q),
        .max_len  (max_len),
        .is_hdr   (is_hdr),
        .is_ftr   (is_ftr),
        .over_len (over_len)
    );

    assign rd = !fifo_empty && !abort && (!valid_q || out_ready);

    always_comb begin
        state_d = state_q;
        len_d   = len_q;
        fwd     = 1'b0;
        cap_id  = 1'b0;
        err_d   = EC_NONE;
        beat_d  = '{data: fifo_data, sof: 1'b0, eof: 1'b0};
        if (abort) begin
            state_d = PS_SKIP;
        end else if (rd) begin
            if (is_hdr) begin
                if (state_q == PS_IDWORD || state_q == PS_BODY) begin
                    err_d = EC_INCOMPLETE;
                end
                fwd        = 1'b1;
                beat_d.sof = 1'b1;
                len_d      = LEN_W'(1);
                state_d    = PS_IDWORD;
            end else begin
                unique case (state_q)
                    PS_EXPECT: begin
                        err_d   = EC_CORRUPT;
                        state_d = PS_SKIP;
                    end
                    PS_SKIP: ;
                    default: begin
                        if (over_len) begin
                            err_d   = EC_JUMBO;
                            state_d = PS_SKIP;
                        end else begin
                            fwd   = 1'b1;
                            len_d = len_q + 1'b1;
                            if (state_q == PS_IDWORD) begin
                                cap_id  = 1'b1;
                                state_d = PS_BODY;
                            end else if (is_ftr) begin
                                beat_d.eof = 1'b1;
                                state_d    = PS_EXPECT;
                            end
                        end
                    end
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= PS_EXPECT;
            len_q     <= '0;
            valid_q   <= 1'b0;
            beat_q    <= '0;
            err_q     <= EC_NONE;
            err_stb_q <= 1'b0;
            evid_q    <= '0;
            bcid_q    <= '0;
        end else begin
            state_q   <= state_d;
            len_q     <= len_d;
            err_q     <= err_d;
            err_stb_q <= err_d != EC_NONE;
            if (fwd) begin
                valid_q <= 1'b1;
                beat_q  <= beat_d;
            end else if (out_ready) begin
                valid_q <= 1'b0;
            end
            if (cap_id) begin
                evid_q <= fifo_data[WORD_W-1 -: EVID_W];
                bcid_q <= fifo_data[BCID_W-1:0];
            end
        end
    end

    rxf_errcnt #(.CNT_W(CNT_W), .NTYPE(NTYPE)) i_cnt (
        .clk  (clk),
        .rst  (rst),
        .stb  (err_stb_q),
        .code (err_q),
        .cnt  (cnt)
    );

    assign fifo_rd        = rd;
    assign out_data       = beat_q.data;
    assign out_sof        = beat_q.sof;
    assign out_eof        = beat_q.eof;
    assign out_valid      = valid_q;
    assign out_evid       = evid_q;
    assign out_bcid       = bcid_q;
    assign err_stb        = err_stb_q;
    assign err_code       = err_q;
    assign cnt_jumbo      = cnt[0];
    assign cnt_incomplete = cnt[1];
    assign cnt_corrupt    = cnt[2];
endmodule

// File: rtl/rxf_parser_chk.sv
module rxf_parser_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             fifo_empty,
    input logic             fifo_rd,
    input logic             abort,
    input logic             out_valid,
    input logic             out_ready,
    input logic [31:0]      out_data,
    input logic             out_sof,
    input logic             out_eof,
    input logic             err_stb,
    input logic [1:0]       err_code,
    input logic [CNT_W-1:0] cnt_corrupt
);
    a_r10_no_read_empty: assert property (@(posedge clk) disable iff (rst)
        fifo_empty |-> !fifo_rd);

    a_r8_abort_blocks_read: assert property (@(posedge clk) disable iff (rst)
        abort |-> !fifo_rd);

    a_r9_hold_under_stall: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)
                                       && $stable(out_sof) && $stable(out_eof)));

    a_r9_no_read_stall: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> !fifo_rd);

    a_r6_code_only_with_strobe: assert property (@(posedge clk) disable iff (rst)
        (err_stb == (err_code != 2'd0)));

    a_r4_incomplete_opens_frame: assert property (@(posedge clk) disable iff (rst)
        (err_stb && err_code == 2'd2) |-> (out_valid && out_sof));

    a_r1_marker_exclusive: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !(out_sof && out_eof));

    a_r7_corrupt_counts: assert property (@(posedge clk) disable iff (rst)
        (err_stb && err_code == 2'd3) |=>
            ((cnt_corrupt == $past(cnt_corrupt) + 1'b1) || ($past(cnt_corrupt) == '1)));
endmodule

bind rxf_parser rxf_parser_chk #(.CNT_W(CNT_W)) i_chk (
    .clk         (clk),
    .rst         (rst),
    .fifo_empty  (fifo_empty),
    .fifo_rd     (fifo_rd),
    .abort       (abort),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_data    (out_data),
    .out_sof     (out_sof),
    .out_eof     (out_eof),
    .err_stb     (err_stb),
    .err_code    (err_code),
    .cnt_corrupt (cnt_corrupt)
);

// File: tb/test_rxf_parser.sv
module test_rxf_parser;
    localparam int LEN_W = 12;
    localparam int EVID_W = 20;
    localparam int CNT_W = 4;
    localparam int NT = 34;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic [31:0] mem [256];
    logic [7:0] rp = 8'd0, wp = 8'd0;
    logic fifo_empty, fifo_rd, abort = 1'b0, out_ready = 1'b1;
    logic [31:0] fifo_data, out_data;
    logic out_sof, out_eof, out_valid, err_stb;
    logic [1:0] err_code;
    logic [EVID_W-1:0] out_evid;
    logic [11:0] out_bcid;
    logic [CNT_W-1:0] cnt_jumbo, cnt_incomplete, cnt_corrupt;
    logic [LEN_W-1:0] max_len = LEN_W'(6);

    assign fifo_empty = (rp == wp);
    assign fifo_data  = mem[rp];
    always @(posedge clk) if (fifo_rd) rp <= rp + 8'd1;

    rxf_parser #(.LEN_W(LEN_W), .EVID_W(EVID_W), .CNT_W(CNT_W)) i_rxf_parser (
        .clk(clk), .rst(rst), .fifo_data(fifo_data), .fifo_empty(fifo_empty),
        .fifo_rd(fifo_rd), .hdr_key(8'hA5), .ftr_key(8'h5A), .max_len(max_len),
        .abort(abort), .out_data(out_data), .out_sof(out_sof), .out_eof(out_eof),
        .out_valid(out_valid), .out_ready(out_ready), .out_evid(out_evid),
        .out_bcid(out_bcid), .err_stb(err_stb), .err_code(err_code),
        .cnt_jumbo(cnt_jumbo), .cnt_incomplete(cnt_incomplete), .cnt_corrupt(cnt_corrupt)
    );

    // entry: {word, forwarded, sof, eof, error code}
    localparam logic [31:0] H = 32'hA500_0001, F = 32'h5A00_0001, D = 32'h0000_0011;
    localparam logic [36:0] TBL [NT] = '{
        {H, 5'b11000}, {32'h0001_20AB, 5'b10000}, {D, 5'b10000}, {F, 5'b10100},
        {H, 5'b11000}, {32'h0034_5111, 5'b10000}, {D, 5'b10000}, {D, 5'b10000},
        {D, 5'b10000}, {F, 5'b10100},
        {D, 5'b00011}, {D, 5'b00000}, {F, 5'b00000},
        {H, 5'b11000}, {32'h0077_7222, 5'b10000}, {F, 5'b10100},
        {H, 5'b11000}, {32'h00AB_C000, 5'b10000}, {D, 5'b10000},
        {H, 5'b11010}, {32'h00DE_F001, 5'b10000}, {F, 5'b10100},
        {H, 5'b11000}, {32'h0111_1000, 5'b10000}, {D, 5'b10000}, {D, 5'b10000},
        {D, 5'b10000}, {D, 5'b10000}, {D, 5'b00001}, {D, 5'b00000}, {F, 5'b00000},
        {H, 5'b11000}, {32'h0222_2000, 5'b10000}, {F, 5'b10100}
    };

    logic [33:0] olog [512];
    logic [EVID_W-1:0] elog_ev [512];
    logic [1:0] elog [512];
    int o_n = 0, e_n = 0, ev_n = 0;
    int n_chk = 0, n_fail = 0;

    always @(negedge clk) if (!rst) begin
        if (out_valid && out_ready) begin
            olog[o_n] <= {out_data, out_sof, out_eof};
            o_n <= o_n + 1;
            if (out_eof) begin
                elog_ev[ev_n] <= out_evid;
                ev_n <= ev_n + 1;
            end
        end
        if (err_stb) begin
            elog[e_n] <= err_code;
            e_n <= e_n + 1;
        end
    end

    task automatic chk(input logic ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push(input logic [31:0] w);
        mem[wp] = w;
        wp = wp + 8'd1;
    endtask

    task automatic drain();
        while (rp != wp) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic clear_logs();
        @(negedge clk);
        o_n = 0; e_n = 0; ev_n = 0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        int k, ke, kv;
        logic [EVID_W-1:0] exp_ev;
        logic want_id;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk(!out_valid && !err_stb && err_code == 0, "R11 reset outputs", {out_valid, err_stb}, 0);
        chk(cnt_jumbo == 0 && cnt_incomplete == 0 && cnt_corrupt == 0, "R11 reset counters",
            {cnt_jumbo, cnt_incomplete, cnt_corrupt}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(!fifo_rd, "R10 no read when empty", fifo_rd, 0);
        chk(!out_valid, "R11 idle after reset", out_valid, 0);

        // table walk: R1 R2 R3 R4 R5 R6
        for (int i = 0; i < NT; i++) push(TBL[i][36:5]);
        drain();
        k = 0; ke = 0; kv = 0; exp_ev = '0; want_id = 1'b0;
        for (int i = 0; i < NT; i++) begin
            if (TBL[i][4]) begin
                chk(k < o_n && olog[k] == {TBL[i][36:5], TBL[i][3:2]},
                    "R1/R3/R4/R5 forwarded word", olog[k], {TBL[i][36:5], TBL[i][3:2]});
                if (want_id) exp_ev = TBL[i][36:17];
                want_id = TBL[i][3];
                if (TBL[i][2]) begin
                    chk(elog_ev[kv] == exp_ev, "R2 event number at footer", elog_ev[kv], exp_ev);
                    kv++;
                end
                k++;
            end
            if (TBL[i][1:0] != 2'd0) begin
                chk(ke < e_n && elog[ke] == TBL[i][1:0], "R6 error code sequence",
                    elog[ke], TBL[i][1:0]);
                ke++;
            end
        end
        chk(o_n == k, "R5 skipped words not forwarded", o_n, k);
        chk(e_n == 3, "R6 one strobe per error", e_n, 3);
        chk(out_bcid == 12'h000 && out_evid == 20'h02222, "R2 last ID fields", {out_evid, out_bcid}, 32'h02222000);
        chk(cnt_jumbo == 1 && cnt_incomplete == 1 && cnt_corrupt == 1, "R7 per-type counters",
            {cnt_jumbo, cnt_incomplete, cnt_corrupt}, 12'h111);

        // R9 backpressure
        clear_logs();
        out_ready = 1'b0;
        push(H); push(32'h0333_3001); push(F);
        repeat (5) @(negedge clk);
        chk(out_valid && out_data == H && out_sof, "R9 output held", out_data, H);
        chk(wp - rp == 8'd2, "R9 no read while stalled", wp - rp, 2);
        out_ready = 1'b1;
        drain();
        chk(o_n == 3 && olog[2] == {F, 2'b01}, "R9 frame completes after stall", o_n, 3);
        chk(out_bcid == 12'h001 && out_evid == 20'h03333, "R2 bunch crossing field", out_bcid, 1);

        // R8 abort
        clear_logs();
        push(H); push(32'h0444_4000);
        drain();
        abort = 1'b1;
        push(D); push(F);
        @(negedge clk);
        chk(!fifo_rd, "R8 no read during abort", fifo_rd, 0);
        abort = 1'b0;
        drain();
        push(H); push(32'h0555_5000); push(F);
        drain();
        chk(o_n == 5, "R8 aborted tail dropped", o_n, 5);
        chk(e_n == 0, "R8 abort raises no error", e_n, 0);
        chk(olog[4] == {F, 2'b01} && olog[2] == {H, 2'b10}, "R8 realign on header", olog[4], {F, 2'b01});

        // R7 saturation of the corrupted counter
        for (int r = 0; r < 17; r++) begin
            push(D); push(H); push(32'h0666_6000); push(F);
            drain();
        end
        chk(cnt_corrupt == 4'hF, "R7 counter saturates", cnt_corrupt, 15);
        chk(cnt_jumbo == 1, "R7 other counters untouched", cnt_jumbo, 1);
        chk(!fifo_rd && fifo_empty, "R10 idle when drained", fifo_rd, 0);
        summary();
    end
endmodule